// File: doc/BRIEF.md
# Sequential Combination Lock Controller

This block is a clocked digital lock. A user presents code digits one at a time on a 4-bit value input and pulses a strobe to enter each one. The lock holds three secret code words. It compares each entered digit with the word for its position and opens only after all three digits have matched in order. A single wrong digit sends the lock into an error state. That state ignores every further entry until the lock is reset.

Inside, a small state machine steers a datapath. The datapath has three code-word registers, a one-hot AND-OR selector that presents the word for the current position, and a bitwise equality comparator whose result goes back to the state machine. The state bits are encoded so that they are the outputs themselves. The low bits are the one-hot selector control and the top bit is the open output, so no output decode logic is needed. The code words are written through their own write port. A lock reset leaves them unchanged.

Top module: `combo_lock`

## Requirements
- R1: While rst_n is low, the state machine is held in the first-digit state: open_o is 0 and the first stored word is the comparand. After reset, a correct three-digit entry opens the lock.
- R2: The state is 4 bits wide: first digit 0001, second 0010, third 0100, open 1000, error 0000. The comparand select is the low three state bits: 001 picks word 0, 010 picks word 1 and 100 picks word 2. The error state selects nothing. open_o is the top state bit, so it is 1 only in the open state.
- R3: In a digit state, a clock edge with digit_strobe_i low leaves the state unchanged, whatever digit_i carries.
- R4: In a digit state, a strobe whose digit equals the selected word moves the state to the next digit state. A match on the third digit moves it to open, and open_o rises on that clock edge.
- R5: In a digit state, a strobe whose digit differs from the selected word moves the state to the error state, and open_o stays 0.
- R6: The error state persists until reset, whatever strobes and digits arrive. A correct sequence entered afterwards does not open the lock.
- R7: The open state persists until reset, whatever strobes and digits arrive.
- R8: A digit matches only if all four bits agree with the selected word. A difference in any single bit position is a mismatch.
- R9: A clock edge with combo_we_i high writes combo_data_i into word combo_idx_i, for indices 0 to 2. Index 3 writes nothing. The words keep their values through lock resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low reset of the lock state (asynchronous assert) |
| digit_i | input | 4 | Entered code digit |
| digit_strobe_i | input | 1 | High for one cycle to enter digit_i |
| combo_we_i | input | 1 | Write enable for the code-word store |
| combo_idx_i | input | 2 | Code-word index to write (0 to 2; 3 is ignored) |
| combo_data_i | input | 4 | Code-word value to write |
| open_o | output | 1 | 1 while the lock is open |

## Verification
On every cycle, the assertions check that the state stays within the five legal codes. They also check that the comparand is zero whenever nothing is selected, that an idle cycle holds the state, that a match advances it by one position and a mismatch clears it, and that the open and error states hold. Several behaviours can only be shown by the bench's scenarios, because they span many cycles or depend on stored data. These are that the code words survive a reset, that writes to index 3 are dropped, that each bit position of a digit matters, and that a correct sequence entered after an error still leaves the lock closed.

// File: rtl/lock_pkg.sv
package lock_pkg;
  // Default geometry of the lock
  localparam int unsigned LOCK_DIGITS  = 3;
  localparam int unsigned LOCK_DIGIT_W = 4;
endpackage

// File: rtl/lock_combo_store.sv
module lock_combo_store #(
  parameter int unsigned NUM_DIGITS = lock_pkg::LOCK_DIGITS,
  parameter int unsigned DIGIT_W    = lock_pkg::LOCK_DIGIT_W,
  localparam int unsigned IDX_W     = $clog2(NUM_DIGITS + 1)
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [IDX_W-1:0]      idx,
  input  logic [DIGIT_W-1:0]    wdata,
  input  logic [NUM_DIGITS-1:0] sel,
  output logic [DIGIT_W-1:0]    word
);

  logic [DIGIT_W-1:0] words_q [NUM_DIGITS];
  logic [DIGIT_W-1:0] terms   [NUM_DIGITS];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_DIGITS; gi++) begin : g_word
      logic wr_en;
      assign wr_en = we && (idx == IDX_W'(gi));
      // Storage has no reset: words survive lock resets
      always_ff @(posedge clk) begin
        if (wr_en) begin
          words_q[gi] <= wdata;
        end
      end
      assign terms[gi] = words_q[gi] & {DIGIT_W{sel[gi]}};
    end
  endgenerate

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      word = word | terms[i];
    end
  end

  // R2: an empty select presents a zero comparand
  always_comb begin
    if (sel == '0) begin
      empty_sel_chk: assert (word == '0);
    end
  end

endmodule

// File: rtl/lock_comparator.sv
module lock_comparator #(
  parameter int unsigned DIGIT_W = lock_pkg::LOCK_DIGIT_W
) (
  input  logic [DIGIT_W-1:0] a,
  input  logic [DIGIT_W-1:0] b,
  output logic               eq
);

  logic [DIGIT_W-1:0] bit_same;

  genvar gb;
  generate
    for (gb = 0; gb < DIGIT_W; gb++) begin : g_bit
      assign bit_same[gb] = ~(a[gb] ^ b[gb]);
    end
  endgenerate

  assign eq = &bit_same;

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm #(
  parameter int unsigned NUM_DIGITS = lock_pkg::LOCK_DIGITS,
  localparam int unsigned ST_W      = NUM_DIGITS + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strobe,
  input  logic                  eq,
  output logic [NUM_DIGITS-1:0] sel,
  output logic                  open
);

  localparam logic [ST_W-1:0] ST_FIRST = ST_W'(1);
  localparam logic [ST_W-1:0] ST_ERR   = '0;

  logic [ST_W-1:0] st_q;
  logic [ST_W-1:0] st_d;
  logic            in_digit;
  logic            st_en;

  assign in_digit = (st_q != ST_ERR) && !st_q[ST_W-1];
  assign st_en    = in_digit && strobe;

  // Next-state: a match shifts the one-hot bit up, the last one lands on open
  always_comb begin
    st_d = st_q;
    if (st_en) begin
      st_d = eq ? (st_q << 1) : ST_ERR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_FIRST;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign sel  = st_q[NUM_DIGITS-1:0];
  assign open = st_q[ST_W-1];

  // R2
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(st_q));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_digit && !strobe) |=> $stable(st_q));

  // R4
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_digit && strobe && eq) |=> ($countones(st_q) == 1 && st_q != $past(st_q)));

  // R5
  mismatch_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_digit && strobe && !eq) |=> (st_q == ST_ERR && !open));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ERR) |=> (st_q == ST_ERR));

  // R7
  open_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open |=> open);

endmodule

// File: rtl/combo_lock.sv
module combo_lock #(
  parameter int unsigned NUM_DIGITS = lock_pkg::LOCK_DIGITS,
  parameter int unsigned DIGIT_W    = lock_pkg::LOCK_DIGIT_W,
  localparam int unsigned IDX_W     = $clog2(NUM_DIGITS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIGIT_W-1:0] digit_i,
  input  logic               digit_strobe_i,
  input  logic               combo_we_i,
  input  logic [IDX_W-1:0]   combo_idx_i,
  input  logic [DIGIT_W-1:0] combo_data_i,
  output logic               open_o
);

  logic [NUM_DIGITS-1:0] sel;
  logic [DIGIT_W-1:0]    cmp_word;
  logic                  eq;

  lock_combo_store #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_store (
    .clk   (clk),
    .we    (combo_we_i),
    .idx   (combo_idx_i),
    .wdata (combo_data_i),
    .sel   (sel),
    .word  (cmp_word)
  );

  lock_comparator #(.DIGIT_W(DIGIT_W)) u_cmp (
    .a  (digit_i),
    .b  (cmp_word),
    .eq (eq)
  );

  lock_fsm #(.NUM_DIGITS(NUM_DIGITS)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (digit_strobe_i),
    .eq     (eq),
    .sel    (sel),
    .open   (open_o)
  );

endmodule

// File: tb/sim_combo_lock.sv
`timescale 1ns/1ps
module sim_combo_lock;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] digit_i = '0;
  logic       digit_strobe_i = 1'b0;
  logic       combo_we_i = 1'b0;
  logic [1:0] combo_idx_i = '0;
  logic [3:0] combo_data_i = '0;
  logic       open_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  combo_lock u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .digit_i        (digit_i),
    .digit_strobe_i (digit_strobe_i),
    .combo_we_i     (combo_we_i),
    .combo_idx_i    (combo_idx_i),
    .combo_data_i   (combo_data_i),
    .open_o         (open_o)
  );

  // Reference model: phase 0..2 = digit position, 3 = open, 4 = error
  int         m_phase;
  logic [3:0] m_word [3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0;
    end else if (digit_strobe_i && m_phase < 3) begin
      if (digit_i === m_word[m_phase]) m_phase <= m_phase + 1;
      else m_phase <= 4;
    end
  end

  always @(posedge clk) begin
    if (combo_we_i && combo_idx_i != 2'd3) m_word[combo_idx_i] <= combo_data_i;
  end

  task automatic check(input logic cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison of the open output against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(open_o === (m_phase == 3), "R2 open only in open state",
            int'(open_o), int'(m_phase == 3));
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    digit_strobe_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load(input logic [1:0] idx, input logic [3:0] val);
    @(negedge clk);
    combo_we_i = 1'b1;
    combo_idx_i = idx;
    combo_data_i = val;
    @(negedge clk);
    combo_we_i = 1'b0;
  endtask

  task automatic put(input logic [3:0] v, input logic s);
    @(negedge clk);
    digit_i = v;
    digit_strobe_i = s;
  endtask

  // Drop the strobe and check the settled output
  task automatic settle_check(input logic exp, input string tag);
    @(negedge clk);
    digit_strobe_i = 1'b0;
    digit_i = 4'h0;
    check(open_o === exp, tag, int'(open_o), int'(exp));
  endtask

  initial begin
    do_reset();
    // R1
    check(open_o === 1'b0, "R1 closed after reset", int'(open_o), 0);
    load(2'd0, 4'h5);
    load(2'd1, 4'hA);
    load(2'd2, 4'h3);
    // R9: index 3 writes nothing
    load(2'd3, 4'hF);

    do_reset();
    // R3: gaps without strobe and a stray digit do nothing
    put(4'h5, 1'b1);
    put(4'hF, 1'b0);
    put(4'h0, 1'b0);
    put(4'hA, 1'b1);
    put(4'h7, 1'b0);
    put(4'h3, 1'b1);
    settle_check(1'b1, "R4 R3 sequence with gaps opens");

    // R7
    put(4'h1, 1'b1);
    put(4'h5, 1'b1);
    put(4'h9, 1'b1);
    settle_check(1'b1, "R7 open ignores strobes");

    do_reset();
    check(open_o === 1'b0, "R1 reset closes", int'(open_o), 0);
    // R4 back-to-back strobes; R9 words retained over reset
    put(4'h5, 1'b1);
    put(4'hA, 1'b1);
    put(4'h3, 1'b1);
    settle_check(1'b1, "R9 R4 words kept across reset");

    do_reset();
    put(4'h6, 1'b1);
    settle_check(1'b0, "R5 wrong first digit closed");
    // R6
    put(4'h5, 1'b1);
    put(4'hA, 1'b1);
    put(4'h3, 1'b1);
    settle_check(1'b0, "R6 error swallows correct sequence");

    // R8: one-bit difference in each position of the third digit
    for (int b = 0; b < 4; b++) begin
      do_reset();
      put(4'h5, 1'b1);
      put(4'hA, 1'b1);
      put(4'h3 ^ (4'h1 << b), 1'b1);
      settle_check(1'b0, "R8 single-bit mismatch");
      put(4'h3, 1'b1);
      settle_check(1'b0, "R6 no recovery after mismatch");
    end

    // R8: one-bit difference in the second digit
    do_reset();
    put(4'h5, 1'b1);
    put(4'hB, 1'b1);
    put(4'h3, 1'b1);
    settle_check(1'b0, "R8 second digit bit0 mismatch");

    // R9: reload with new words; old code fails, new one opens
    load(2'd0, 4'hC);
    load(2'd1, 4'h0);
    load(2'd2, 4'hF);
    do_reset();
    put(4'h5, 1'b1);
    settle_check(1'b0, "R9 old word rejected");
    do_reset();
    put(4'hC, 1'b1);
    put(4'h0, 1'b1);
    put(4'hF, 1'b1);
    settle_check(1'b1, "R9 new words open");

    // R1: reset while strobing a matching digit
    @(negedge clk);
    rst_n = 1'b0;
    digit_i = 4'hC;
    digit_strobe_i = 1'b1;
    @(negedge clk);
    check(open_o === 1'b0, "R1 reset dominates strobe", int'(open_o), 0);
    rst_n = 1'b1;
    digit_strobe_i = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule